// File: doc/BRIEF.md
# Suspend Refresh Interval Timer

This block paces CAS-before-RAS refresh requests to DRAM while the system is suspended. The pacing clock is a slow free-running oscillator. The block samples that oscillator in the system clock domain and detects its rising edges. A down-counter is loaded with a programmable interval and decrements on every detected edge. Each time the counter expires it reloads and raises a refresh request. The request stays high until the DRAM controller acknowledges it. Expiries that arrive before the acknowledge are queued in a small saturating pending counter.

A 16-bit host control register holds the interval reload value and an auto-adjust enable. When auto-adjust is on, a calibration engine counts oscillator edges over a window of 2^WIN_LOG2 system clocks. It scales that count to the number of oscillator cycles in a 15.5 µs target interval and writes the result into the reload field. The host can still read and write the field at any time, and a host write beats a hardware update in the same cycle. The register is cleared only by the cold reset. The warm (bus) reset that comes with resume from suspend restarts the counter, the request logic and the calibration, but leaves the register untouched.

The block has three state machines.
- Interval machine: state IV_LOAD moves to IV_RUN after loading the counter. IV_RUN holds until a reset.
- Request machine: state RQ_IDLE moves to RQ_WAIT when a request becomes pending. RQ_WAIT moves back to RQ_IDLE when the pending count drains to zero.
- Calibration machine: state CAL_IDLE moves to CAL_MEASURE when auto-adjust is enabled. CAL_MEASURE moves to CAL_COMMIT at the end of the window, or back to CAL_IDLE if auto-adjust is disabled. CAL_COMMIT moves to CAL_MEASURE (still enabled) or to CAL_IDLE (disabled).

Top module: `susp_refresh_timer`

## Requirements
- R1: The read value places the reload field in bits 11:0 and the auto-adjust enable in bit 12. Bits 15:13 always read as zero, and writes to them are ignored.
- R2: Cold reset sets the register to 0x0038 (reload 56, auto-adjust off), drops the refresh request and clears the pending count.
- R3: Warm reset leaves the register value unchanged. It drops the refresh request and clears the pending count.
- R4: With a nonzero reload value R, consecutive refresh requests are spaced exactly R+1 oscillator periods apart. On expiry the counter reloads from the current field.
- R5: A reload value of zero acts as 4096, which spaces the requests 4097 oscillator periods apart.
- R6: A refresh request stays high until acknowledged. Each acknowledge removes one pending request, and the request drops when none remain.
- R7: Expiries that occur before an acknowledge accumulate in a 2-bit pending count that saturates at 3.
- R8: With auto-adjust on, after each window of 2^WIN_LOG2 system clocks the reload field becomes floor(E × 15.5 µs ÷ window time), where E is the number of oscillator rising edges seen in that window.
- R9: The calibrated value is clamped to the range 1 to 4095. With the oscillator stopped, the field becomes 1.
- R10: Host writes take effect at once and are readable in the next cycle, even while auto-adjust is on. A host write wins over a hardware update in the same cycle.
- R11: With auto-adjust off, the reload field changes only through host writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| cold_rst_n | input | 1 | Cold reset, active low, synchronous; clears everything |
| warm_rst_n | input | 1 | Warm/bus reset, active low, synchronous; spares the register |
| osc_clk | input | 1 | Free-running slow oscillator, sampled in the clk domain |
| reg_wr | input | 1 | Host write strobe for the control register |
| reg_wdata | input | 16 | Host write data |
| reg_rdata | output | 16 | Current control register contents |
| refresh_req | output | 1 | Suspend refresh request, held until acknowledged |
| refresh_ack | input | 1 | Acknowledge from the DRAM controller, one request per cycle |
| pend_cnt | output | 2 | Number of outstanding refresh requests |

## Verification
The bench builds the block with WIN_LOG2 = 8, a 10 ns system period and the 15.5 µs target. A calibration window is therefore 256 clocks. Oscillator periods of 4, 8, 16 and 32 clocks divide the window exactly, so the edge count and the calibrated reload (387, 193, 96 and 48) are exact rather than off by one. This short window lets several recalibrations, the stopped-oscillator clamp and a full 4097-period interval with reload zero all fit within the run. With these parameters the upper clamp at 4095 cannot be reached.

// File: rtl/srt_pkg.sv
package srt_pkg;

    // Width of the host-visible control register
    localparam int REG_W = 16;

    // Interval counter sequencing
    typedef enum logic [0:0] {
        IV_LOAD = 1'b0,
        IV_RUN  = 1'b1
    } iv_state_e;

    // Refresh request handshake
    typedef enum logic [0:0] {
        RQ_IDLE = 1'b0,
        RQ_WAIT = 1'b1
    } rq_state_e;

    // Oscillator calibration
    typedef enum logic [1:0] {
        CAL_IDLE    = 2'd0,
        CAL_MEASURE = 2'd1,
        CAL_COMMIT  = 2'd2
    } cal_state_e;

endpackage

// File: rtl/srt_ctrl_reg.sv
module srt_ctrl_reg
    import srt_pkg::*;
#(
    parameter int              RLD_W   = 12,
    parameter logic [RLD_W-1:0] DEF_RLD = 12'd56
) (
    input  logic             clk,
    input  logic             cold_rst_n,
    input  logic             host_wr,
    input  logic [RLD_W:0]   host_wdata,
    input  logic             hw_wr,
    input  logic [RLD_W-1:0] hw_rld,
    output logic             auto_en,
    output logic [RLD_W-1:0] rld,
    output logic [REG_W-1:0] rdata
);

    // Only the cold reset reaches this register; the host write wins
    // over the calibration update when both arrive together.
    always_ff @(posedge clk) begin
        if (!cold_rst_n) begin
            rld     <= DEF_RLD;
            auto_en <= 1'b0;
        end else if (host_wr) begin
            rld     <= host_wdata[RLD_W-1:0];
            auto_en <= host_wdata[RLD_W];
        end else if (hw_wr) begin
            rld     <= hw_rld;
        end
    end

    always_comb begin
        rdata             = '0;
        rdata[RLD_W-1:0]  = rld;
        rdata[RLD_W]      = auto_en;
    end

endmodule

// File: rtl/srt_osc_edge.sv
module srt_osc_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_in,
    output logic osc_rise
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], osc_in};
            prev_q <= sync_q[SYNC_STAGES-1];
        end
    end

    assign osc_rise = sync_q[SYNC_STAGES-1] & ~prev_q;

endmodule

// File: rtl/srt_interval.sv
module srt_interval
    import srt_pkg::*;
#(
    parameter int RLD_W  = 12,
    parameter int PEND_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_rise,
    input  logic [RLD_W-1:0]  rld,
    input  logic              ack,
    output logic              expire,
    output logic              req,
    output logic [PEND_W-1:0] pend
);

    localparam int                CNT_W    = RLD_W + 1;
    localparam logic [PEND_W-1:0] PEND_MAX = {PEND_W{1'b1}};

    iv_state_e          iv_q, iv_d;
    rq_state_e          rq_q, rq_d;
    logic [CNT_W-1:0]   cnt_q;
    logic [CNT_W-1:0]   reload_eff;
    logic [PEND_W-1:0]  pend_d;
    logic               take, give;

    // A zero field stands for the full counter range
    assign reload_eff = (rld == '0) ? (CNT_W'(1) << RLD_W) : {1'b0, rld};

    // ---------------- interval machine ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) iv_q <= IV_LOAD;
        else        iv_q <= iv_d;
    end

    always_comb begin
        iv_d = iv_q;
        unique case (iv_q)
            IV_LOAD: iv_d = IV_RUN;
            IV_RUN:  iv_d = IV_RUN;
        endcase
    end

    assign expire = (iv_q == IV_RUN) && osc_rise && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            unique case (iv_q)
                IV_LOAD: cnt_q <= reload_eff;
                IV_RUN: begin
                    if (osc_rise) begin
                        if (cnt_q == '0) cnt_q <= reload_eff;
                        else             cnt_q <= cnt_q - 1'b1;
                    end
                end
            endcase
        end
    end

    // ---------------- request machine ----------------
    assign give = ack && (pend != '0);
    assign take = expire && ((pend != PEND_MAX) || give);

    always_comb begin
        pend_d = pend;
        if (take && !give)      pend_d = pend + 1'b1;
        else if (give && !take) pend_d = pend - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rq_q <= RQ_IDLE;
            pend <= '0;
        end else begin
            rq_q <= rq_d;
            pend <= pend_d;
        end
    end

    always_comb begin
        rq_d = rq_q;
        unique case (rq_q)
            RQ_IDLE: if (pend_d != '0) rq_d = RQ_WAIT;
            RQ_WAIT: if (pend_d == '0) rq_d = RQ_IDLE;
        endcase
    end

    always_comb begin
        req = 1'b0;
        unique case (rq_q)
            RQ_IDLE: req = 1'b0;
            RQ_WAIT: req = 1'b1;
        endcase
    end

endmodule

// File: rtl/srt_calib.sv
module srt_calib
    import srt_pkg::*;
#(
    parameter int RLD_W         = 12,
    parameter int WIN_LOG2      = 12,
    parameter int SYS_PERIOD_PS = 10000,
    parameter int TARGET_PS     = 15500000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             osc_rise,
    output logic             hw_wr,
    output logic [RLD_W-1:0] hw_rld
);

    localparam int          WIN_CYC = 1 << WIN_LOG2;
    localparam int          EC_W    = WIN_LOG2 + 1;
    localparam logic [63:0] WIN_PS  = 64'(WIN_CYC) * 64'(SYS_PERIOD_PS);
    localparam logic [63:0] RLD_MAX = (64'd1 << RLD_W) - 64'd1;

    cal_state_e          st_q, st_d;
    logic [WIN_LOG2-1:0] win_q;
    logic [EC_W-1:0]     edges_q;
    logic [63:0]         scaled;

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= CAL_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CAL_IDLE:    if (en) st_d = CAL_MEASURE;
            CAL_MEASURE: begin
                if (!en)                                  st_d = CAL_IDLE;
                else if (win_q == WIN_LOG2'(WIN_CYC - 1)) st_d = CAL_COMMIT;
            end
            CAL_COMMIT:  st_d = en ? CAL_MEASURE : CAL_IDLE;
            default:     st_d = CAL_IDLE;
        endcase
    end

    // Window and edge counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q   <= '0;
            edges_q <= '0;
        end else if (st_q == CAL_MEASURE) begin
            win_q <= win_q + 1'b1;
            if (osc_rise) edges_q <= edges_q + 1'b1;
        end else begin
            win_q   <= '0;
            edges_q <= '0;
        end
    end

    // Scale edges in the window to oscillator cycles per target interval
    assign scaled = (64'(edges_q) * 64'(TARGET_PS)) / WIN_PS;

    always_comb begin
        hw_wr  = 1'b0;
        hw_rld = '0;
        unique case (st_q)
            CAL_IDLE, CAL_MEASURE: hw_wr = 1'b0;
            CAL_COMMIT:            hw_wr = en && rst_n;
            default:               hw_wr = 1'b0;
        endcase
        if (scaled == 64'd0)       hw_rld = RLD_W'(1);
        else if (scaled > RLD_MAX) hw_rld = RLD_MAX[RLD_W-1:0];
        else                       hw_rld = scaled[RLD_W-1:0];
    end

endmodule

// File: rtl/susp_refresh_timer.sv
module susp_refresh_timer
    import srt_pkg::*;
#(
    parameter int RLD_W         = 12,
    parameter int DEF_RLD       = 56,
    parameter int WIN_LOG2      = 12,
    parameter int SYS_PERIOD_PS = 10000,
    parameter int TARGET_PS     = 15500000,
    parameter int PEND_W        = 2
) (
    input  logic              clk,
    input  logic              cold_rst_n,
    input  logic              warm_rst_n,
    input  logic              osc_clk,
    input  logic              reg_wr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    output logic              refresh_req,
    input  logic              refresh_ack,
    output logic [PEND_W-1:0] pend_cnt
);

    logic             op_rst_n;
    logic             osc_rise;
    logic             auto_en;
    logic [RLD_W-1:0] cur_rld;
    logic             cal_wr;
    logic [RLD_W-1:0] cal_rld;
    logic             iv_expire;
    logic             unused_rsv;

    // Everything except the register restarts on either reset
    assign op_rst_n   = cold_rst_n & warm_rst_n;
    assign unused_rsv = ^reg_wdata[REG_W-1:RLD_W+1];

    srt_ctrl_reg #(
        .RLD_W   (RLD_W),
        .DEF_RLD (RLD_W'(DEF_RLD))
    ) i_reg (
        .clk        (clk),
        .cold_rst_n (cold_rst_n),
        .host_wr    (reg_wr),
        .host_wdata (reg_wdata[RLD_W:0]),
        .hw_wr      (cal_wr),
        .hw_rld     (cal_rld),
        .auto_en    (auto_en),
        .rld        (cur_rld),
        .rdata      (reg_rdata)
    );

    srt_osc_edge #(
        .SYNC_STAGES (2)
    ) i_edge (
        .clk      (clk),
        .rst_n    (op_rst_n),
        .osc_in   (osc_clk),
        .osc_rise (osc_rise)
    );

    srt_interval #(
        .RLD_W  (RLD_W),
        .PEND_W (PEND_W)
    ) i_interval (
        .clk      (clk),
        .rst_n    (op_rst_n),
        .osc_rise (osc_rise),
        .rld      (cur_rld),
        .ack      (refresh_ack),
        .expire   (iv_expire),
        .req      (refresh_req),
        .pend     (pend_cnt)
    );

    srt_calib #(
        .RLD_W         (RLD_W),
        .WIN_LOG2      (WIN_LOG2),
        .SYS_PERIOD_PS (SYS_PERIOD_PS),
        .TARGET_PS     (TARGET_PS)
    ) i_calib (
        .clk      (clk),
        .rst_n    (op_rst_n),
        .en       (auto_en),
        .osc_rise (osc_rise),
        .hw_wr    (cal_wr),
        .hw_rld   (cal_rld)
    );

endmodule

// File: rtl/srt_chk.sv
module srt_chk #(
    parameter int RLD_W  = 12,
    parameter int PEND_W = 2
) (
    input logic              clk,
    input logic              cold_rst_n,
    input logic              warm_rst_n,
    input logic              reg_wr,
    input logic [15:0]       reg_wdata,
    input logic [15:0]       reg_rdata,
    input logic              refresh_req,
    input logic              refresh_ack,
    input logic [PEND_W-1:0] pend_cnt,
    input logic              cal_wr,
    input logic [RLD_W-1:0]  cal_rld,
    input logic              expire
);

    localparam logic [PEND_W-1:0] PEND_MAX = {PEND_W{1'b1}};

    // R3
    warm_keeps_reg_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
        (!warm_rst_n && !reg_wr) |=> $stable(reg_rdata));

    // R10
    host_wins_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
        reg_wr |=> (reg_rdata[RLD_W:0] == $past(reg_wdata[RLD_W:0])));

    // R11
    no_hw_write_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
        (!reg_rdata[RLD_W] && !reg_wr) |=> $stable(reg_rdata[RLD_W-1:0]));

    // R6
    req_hold_chk: assert property (@(posedge clk) disable iff (!cold_rst_n || !warm_rst_n)
        (refresh_req && !refresh_ack) |=> refresh_req);

    // R6
    ack_drain_chk: assert property (@(posedge clk) disable iff (!cold_rst_n || !warm_rst_n)
        (refresh_req && refresh_ack && !expire) |=> (pend_cnt == $past(pend_cnt) - 1'b1));

    // R7
    pend_sat_chk: assert property (@(posedge clk) disable iff (!cold_rst_n || !warm_rst_n)
        (pend_cnt == PEND_MAX && !refresh_ack) |=> (pend_cnt == PEND_MAX));

    // R9
    cal_floor_chk: assert property (@(posedge clk) disable iff (!cold_rst_n || !warm_rst_n)
        cal_wr |-> (cal_rld != '0));

endmodule

bind susp_refresh_timer srt_chk #(
    .RLD_W  (RLD_W),
    .PEND_W (PEND_W)
) i_srt_chk (
    .clk         (clk),
    .cold_rst_n  (cold_rst_n),
    .warm_rst_n  (warm_rst_n),
    .reg_wr      (reg_wr),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .refresh_req (refresh_req),
    .refresh_ack (refresh_ack),
    .pend_cnt    (pend_cnt),
    .cal_wr      (cal_wr),
    .cal_rld     (cal_rld),
    .expire      (iv_expire)
);

// File: tb/test_susp_refresh_timer.sv
module test_susp_refresh_timer;

    localparam int WIN_LOG2 = 8;
    localparam int SYS_PS   = 10000;
    localparam int TGT_PS   = 15500000;
    localparam int WIN_CYC  = 1 << WIN_LOG2;
    localparam int SETTLE   = 3 * (WIN_CYC + 1) + 20;

    logic        clk = 1'b0;
    logic        cold_rst_n = 1'b0;
    logic        warm_rst_n = 1'b1;
    logic        osc_clk = 1'b0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        refresh_req;
    logic        refresh_ack = 1'b0;
    logic [1:0]  pend_cnt;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    int osc_half = 2;
    bit osc_stop = 1'b0;

    susp_refresh_timer #(
        .WIN_LOG2      (WIN_LOG2),
        .SYS_PERIOD_PS (SYS_PS),
        .TARGET_PS     (TGT_PS)
    ) i_susp_refresh_timer (
        .clk         (clk),
        .cold_rst_n  (cold_rst_n),
        .warm_rst_n  (warm_rst_n),
        .osc_clk     (osc_clk),
        .reg_wr      (reg_wr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .refresh_req (refresh_req),
        .refresh_ack (refresh_ack),
        .pend_cnt    (pend_cnt)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        forever begin
            repeat (osc_half) @(negedge clk);
            osc_clk = osc_stop ? 1'b0 : ~osc_clk;
        end
    end

    function automatic int exp_rld(int edges);
        longint v;
        v = (longint'(edges) * longint'(TGT_PS)) / (longint'(WIN_CYC) * longint'(SYS_PS));
        if (v < 1)    v = 1;
        if (v > 4095) v = 4095;
        return int'(v);
    endfunction

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr_reg(logic [15:0] v);
        reg_wdata = v;
        reg_wr    = 1'b1;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic warm_pulse();
        warm_rst_n = 1'b0;
        repeat (2) @(negedge clk);
        warm_rst_n = 1'b1;
    endtask

    task automatic next_req(output int t);
        while (!refresh_req) @(negedge clk);
        t = cyc;
        refresh_ack = 1'b1;
        @(negedge clk);
        refresh_ack = 1'b0;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        int t1, t2;
        int periods[4];
        void'($urandom(32'h5eed));
        periods = '{16, 4, 32, 8};

        repeat (3) @(negedge clk);
        cold_rst_n = 1'b1;
        @(negedge clk);

        // R2: cold reset state
        chk("R2 reset register", reg_rdata, 16'h0038);
        chk("R2 reset request", refresh_req, 0);
        chk("R2 reset pending", pend_cnt, 0);

        // R1: reserved bits read zero, field placement
        wr_reg(16'hFFFF);
        chk("R1 all ones write", reg_rdata, 16'h1FFF);
        wr_reg(16'hE123);
        chk("R1 reserved ignored", reg_rdata, 16'h0123);

        // R4: random reload values and oscillator periods
        for (int i = 0; i < 6; i++) begin
            int r, p;
            r = $urandom_range(1, 12);
            p = 2 * $urandom_range(2, 5);
            osc_half = p / 2;
            wr_reg(16'(r));
            warm_pulse();
            next_req(t1);
            next_req(t2);
            chk("R4 request spacing", t2 - t1, (r + 1) * p);
        end

        // R5: zero reload acts as 4096
        osc_half = 2;
        wr_reg(16'h0000);
        warm_pulse();
        next_req(t1);
        next_req(t2);
        chk("R5 zero reload spacing", t2 - t1, 4097 * 4);

        // R7: pending saturates without acknowledge
        wr_reg(16'h0002);
        warm_pulse();
        repeat (100) @(negedge clk);
        chk("R7 pending saturated", pend_cnt, 3);
        chk("R7 request high", refresh_req, 1);

        // R6: each acknowledge drains one
        osc_stop = 1'b1;
        repeat (12) @(negedge clk);
        for (int k = 2; k >= 0; k--) begin
            refresh_ack = 1'b1;
            @(negedge clk);
            refresh_ack = 1'b0;
            chk("R6 pending after ack", pend_cnt, k);
            chk("R6 request level", refresh_req, (k != 0) ? 1 : 0);
        end

        // R3: warm reset spares the register
        osc_stop = 1'b0;
        repeat (100) @(negedge clk);
        warm_rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R3 register during warm reset", reg_rdata, 16'h0002);
        warm_rst_n = 1'b1;
        @(negedge clk);
        chk("R3 register after warm reset", reg_rdata, 16'h0002);
        chk("R3 pending cleared", pend_cnt, 0);
        chk("R3 request cleared", refresh_req, 0);

        // R8: calibration against several oscillator periods
        for (int i = 0; i < 4; i++) begin
            osc_half = periods[i] / 2;
            wr_reg(16'h1005);
            repeat (SETTLE) @(negedge clk);
            chk("R8 calibrated reload", reg_rdata, 16'h1000 | exp_rld(WIN_CYC / periods[i]));
        end

        // R9: stopped oscillator clamps to one
        osc_stop = 1'b1;
        repeat (SETTLE) @(negedge clk);
        chk("R9 clamp low", reg_rdata, 16'h1000 | exp_rld(0));
        osc_stop = 1'b0;
        osc_half = 4;

        // R10: host writes every cycle while calibration runs
        for (int i = 0; i < 300; i++) begin
            logic [15:0] v;
            v = 16'h1000 | 16'($urandom_range(0, 4095));
            reg_wdata = v;
            reg_wr    = 1'b1;
            @(negedge clk);
            chk("R10 host write readback", reg_rdata, v);
        end
        reg_wr = 1'b0;

        // R11: auto-adjust off keeps the field
        wr_reg(16'h0123);
        repeat (SETTLE) @(negedge clk);
        chk("R11 field stable with auto off", reg_rdata, 16'h0123);

        // R2: cold reset restores the default
        cold_rst_n = 1'b0;
        repeat (2) @(negedge clk);
        cold_rst_n = 1'b1;
        @(negedge clk);
        chk("R2 cold reset restores", reg_rdata, 16'h0038);
        chk("R2 cold reset pending", pend_cnt, 0);

        summary();
        $finish;
    end

endmodule